// File: doc/BRIEF.md
# Conditional Line-Flip Fault Injector

This block sits on one victim signal of a design under test and emulates a logic fault on it. Every cycle it takes the fault-free value of the victim line and either passes it through or inverts it. It inverts when a programmable activation condition holds. The condition is built from the values on an aggressor bus, in the current cycle and in the cycle before. The corrupted value and an activation flag both leave the block through registers, one cycle after the inputs that produced them. A bench can count the flag to see how often the fault fired.

The condition is a sum of up to four product terms. Each term states, for each aggressor bit, whether the current value matters and what it must be, and whether the previous-cycle value matters and what it must be. A term that checks only current values describes a static fault, such as a bridge in which one line dominates another. A term that also checks previous values describes a transition-triggered fault, such as a flip on a rising edge of a neighbour. Several terms ORed together cover faults that need more than one minterm. If an aggressor bit is wired to the victim line itself, a single term reproduces a stuck-at fault.

The configuration is held in a bank that reset does not clear, and it can be written while reset is asserted. The datapath registers, including the copy of the previous aggressor values, are cleared by reset. For one cycle after reset, any term that depends on previous values is held off.

Top module: `cond_flip_injector`

## Requirements
- R1: While rst_n is low, victim_out and fault_active are 0 and the stored previous aggressor value is cleared. Reset leaves the term configuration untouched, and cfg_we writes are accepted during reset.
- R2: On each clock edge out of reset, victim_out takes victim_in XOR act, where act is the activation computed from the inputs at that edge, and fault_active takes act. Both outputs therefore lag the inputs by one cycle.
- R3: For aggressor bit i, cfg_code[3i] means the current value matters and cfg_code[3i+1] gives the value it must have. A term can hit only if every such bit of aggr equals its required value.
- R4: cfg_code[3i+2] means the previous-cycle value of bit i matters, and cfg_prev_val[i] gives the value it must have had. A term can hit only if every such bit of the previous aggr value matches.
- R5: act is en AND the OR of all four terms. Each term is the AND of its R3 and R4 conditions, so a fault can be described as two or more ORed products, for example an event on one line whose new value differs from a second line.
- R6: A term whose 3-bit codes are all zero is disabled and never hits, whatever the aggressor values.
- R7: When en is 0, act is 0: victim_out equals the delayed victim_in and fault_active is 0.
- R8: In the first cycle after reset is released, a term that has any previous-value care bit cannot hit. Terms that check only current values can hit in that cycle.
- R9: A cycle with cfg_we high stores cfg_code and cfg_prev_val into term cfg_sel. The new setting governs act from the next cycle on, and the other terms keep their settings.
- R10: If aggressor bit 0 carries the victim value, a term that requires current bit 0 = 1 makes victim_out constantly 0 (stuck-at-0). A term that requires 0 makes it constantly 1 (stuck-at-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the datapath registers |
| en | input | 1 | Global fault enable |
| victim_in | input | 1 | Fault-free value of the victim line |
| aggr | input | AGG_W | Aggressor signal bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Index of the term being written |
| cfg_code | input | 3*AGG_W | Per-bit 3-bit codes: care-current, required current value, care-previous |
| cfg_prev_val | input | AGG_W | Required previous-cycle value per bit |
| victim_out | output | 1 | Registered, possibly inverted victim value |
| fault_active | output | 1 | Registered activation flag, aligned with victim_out |

## Verification
A configuration write and a fault evaluation can land in the same cycle. The bench provokes this by writing a term while en is high and the aggressor value matches the new setting but not the old one. It then expects the old setting to govern that cycle and the new one to govern the following cycle. The bench also lets a transition term and the warm-up gate after reset meet in the same cycle. It releases reset with a rising-edge term loaded and drives the qualifying current value at once, and it expects no flip until one real previous value has been captured.

// File: rtl/cfi_pkg.sv
package cfi_pkg;

    // Per-aggressor-bit control code, bit 0 lowest.
    typedef struct packed {
        logic care_prev;   // bit 2
        logic val_cur;     // bit 1
        logic care_cur;    // bit 0
    } bit_code_t;

    localparam int unsigned CODE_W = $bits(bit_code_t);

endpackage

// File: rtl/cfi_cfg_bank.sv
module cfi_cfg_bank
    import cfi_pkg::*;
#(
    parameter int unsigned AGG_W = 8,
    parameter int unsigned NTERM = 4,
    localparam int unsigned SEL_W = (NTERM > 1) ? $clog2(NTERM) : 1,
    localparam int unsigned TCW   = CODE_W * AGG_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  logic [TCW-1:0]         cfg_code,
    input  logic [AGG_W-1:0]       cfg_prev_val,
    output logic [NTERM*TCW-1:0]   code_all,
    output logic [NTERM*AGG_W-1:0] pval_all
);

    typedef struct packed {
        logic [TCW-1:0]   code;
        logic [AGG_W-1:0] pval;
    } term_cfg_t;

    term_cfg_t bank_d [NTERM];
    term_cfg_t bank_q [NTERM];

    always_comb begin
        for (int k = 0; k < NTERM; k++) begin
            bank_d[k] = bank_q[k];
            if (cfg_we && (int'(cfg_sel) == k)) begin
                bank_d[k].code = cfg_code;
                bank_d[k].pval = cfg_prev_val;
            end
        end
    end

    // Configuration is software state: reset leaves it alone.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NTERM; k++) begin
            bank_q[k] <= bank_d[k];
        end
    end

    for (genvar k = 0; k < NTERM; k++) begin : g_out
        assign code_all[k*TCW +: TCW]     = bank_q[k].code;
        assign pval_all[k*AGG_W +: AGG_W] = bank_q[k].pval;
    end

    // R9
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_sel) < NTERM)) |=>
            (bank_q[$past(cfg_sel)].code == $past(cfg_code)) &&
            (bank_q[$past(cfg_sel)].pval == $past(cfg_prev_val)));

endmodule

// File: rtl/cfi_term_match.sv
module cfi_term_match
    import cfi_pkg::*;
#(
    parameter int unsigned AGG_W = 8,
    localparam int unsigned TCW  = CODE_W * AGG_W
) (
    input  logic [TCW-1:0]   code,
    input  logic [AGG_W-1:0] prev_val,
    input  logic [AGG_W-1:0] aggr,
    input  logic [AGG_W-1:0] aggr_prev,
    input  logic             prev_ok,
    output logic             hit,
    output logic             dyn
);

    logic [AGG_W-1:0] care_cur, val_cur, care_prev;

    for (genvar i = 0; i < AGG_W; i++) begin : g_bit
        bit_code_t bc;
        assign bc           = bit_code_t'(code[i*CODE_W +: CODE_W]);
        assign care_cur[i]  = bc.care_cur;
        assign val_cur[i]   = bc.val_cur;
        assign care_prev[i] = bc.care_prev;
    end

    logic miss_cur, miss_prev, any_care;

    always_comb begin
        miss_cur  = |(care_cur & (aggr ^ val_cur));
        miss_prev = |(care_prev & (aggr_prev ^ prev_val));
        any_care  = |(care_cur | care_prev);
        dyn       = |care_prev;
        hit       = any_care && !miss_cur && !miss_prev && (!dyn || prev_ok);
    end

endmodule

// File: rtl/cond_flip_injector.sv
module cond_flip_injector
    import cfi_pkg::*;
#(
    parameter int unsigned AGG_W = 8,
    parameter int unsigned NTERM = 4,
    localparam int unsigned SEL_W = (NTERM > 1) ? $clog2(NTERM) : 1,
    localparam int unsigned TCW   = CODE_W * AGG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             victim_in,
    input  logic [AGG_W-1:0] aggr,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [TCW-1:0]   cfg_code,
    input  logic [AGG_W-1:0] cfg_prev_val,
    output logic             victim_out,
    output logic             fault_active
);

    typedef struct packed {
        logic [AGG_W-1:0] prev;
        logic             prev_ok;
        logic             victim;
        logic             active;
    } state_t;

    state_t st_d, st_q;

    logic [NTERM*TCW-1:0]   code_all;
    logic [NTERM*AGG_W-1:0] pval_all;
    logic [NTERM-1:0]       term_hit;
    logic [NTERM-1:0]       term_dyn;

    cfi_cfg_bank #(.AGG_W(AGG_W), .NTERM(NTERM)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_code     (cfg_code),
        .cfg_prev_val (cfg_prev_val),
        .code_all     (code_all),
        .pval_all     (pval_all)
    );

    for (genvar k = 0; k < NTERM; k++) begin : g_term
        cfi_term_match #(.AGG_W(AGG_W)) u_match (
            .code      (code_all[k*TCW +: TCW]),
            .prev_val  (pval_all[k*AGG_W +: AGG_W]),
            .aggr      (aggr),
            .aggr_prev (st_q.prev),
            .prev_ok   (st_q.prev_ok),
            .hit       (term_hit[k]),
            .dyn       (term_dyn[k])
        );

        // R6
        idle_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code_all[k*TCW +: TCW] == '0) |-> !term_hit[k]);
    end

    always_comb begin
        logic act;
        act          = en && (|term_hit);
        st_d.prev    = aggr;
        st_d.prev_ok = 1'b1;
        st_d.victim  = victim_in ^ act;
        st_d.active  = act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_out   = st_q.victim;
    assign fault_active = st_q.active;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!victim_out && !fault_active));

    // R2
    flip_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (victim_out == ($past(victim_in) ^ fault_active)));

    // R7
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fault_active);

    // R8
    warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.prev_ok |-> !(|(term_hit & term_dyn)));

endmodule

// File: tb/cond_flip_injector_bench.sv
module cond_flip_injector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NT = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          victim_in = 1'b0;
    logic [AW-1:0] aggr = '0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic [3*AW-1:0] cfg_code = '0;
    logic [AW-1:0] cfg_prev_val = '0;
    logic          victim_out, fault_active;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    logic [3*AW-1:0] m_code [NT];
    logic [AW-1:0]   m_pv   [NT];
    logic [AW-1:0]   m_prev = '0;
    bit              m_ok = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flip_injector #(.AGG_W(AW), .NTERM(NT)) u_cond_flip_injector (
        .clk(clk), .rst_n(rst_n), .en(en), .victim_in(victim_in), .aggr(aggr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
        .cfg_prev_val(cfg_prev_val), .victim_out(victim_out),
        .fault_active(fault_active)
    );

    // Code layout from R3/R4: bit 3i care-current, 3i+1 value, 3i+2 care-previous.
    function automatic logic [3*AW-1:0] mk(input logic [AW-1:0] cc,
                                           input logic [AW-1:0] vc,
                                           input logic [AW-1:0] cp);
        logic [3*AW-1:0] r = '0;
        for (int i = 0; i < AW; i++) begin
            r[3*i]   = cc[i];
            r[3*i+1] = vc[i];
            r[3*i+2] = cp[i];
        end
        return r;
    endfunction

    function automatic bit term_hit(input int k, input logic [AW-1:0] a);
        bit any = 0, dyn = 0;
        for (int i = 0; i < AW; i++) begin
            if (m_code[k][3*i] || m_code[k][3*i+2]) any = 1;
            if (m_code[k][3*i] && (a[i] != m_code[k][3*i+1])) return 0;
            if (m_code[k][3*i+2]) begin
                dyn = 1;
                if (m_prev[i] != m_pv[k][i]) return 0;
            end
        end
        return any && (!dyn || m_ok);
    endfunction

    task automatic check(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0b exp=%0b", cur_req, what, got, exp);
        end
    endtask

    // One cycle out of reset; inputs driven just after a falling edge.
    task automatic cyc_w(input logic we, input logic [SW-1:0] sel,
                         input logic [3*AW-1:0] code, input logic [AW-1:0] pv,
                         input logic v, input logic [AW-1:0] a, input logic e);
        bit act = 0;
        for (int k = 0; k < NT; k++) act |= term_hit(k, a);
        act &= e;
        cfg_we = we; cfg_sel = sel; cfg_code = code; cfg_prev_val = pv;
        victim_in = v; aggr = a; en = e;
        @(posedge clk);
        m_prev = a;
        m_ok = 1;
        if (we) begin
            m_code[sel] = code;
            m_pv[sel] = pv;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(victim_out, v ^ act, "victim_out");
        check(fault_active, act, "fault_active");
    endtask

    task automatic cyc(input logic v, input logic [AW-1:0] a, input logic e);
        cyc_w(1'b0, '0, '0, '0, v, a, e);
    endtask

    // Write during reset (R1: config accepted while reset asserted).
    task automatic wr_rst(input logic [SW-1:0] sel, input logic [3*AW-1:0] code,
                          input logic [AW-1:0] pv);
        cfg_we = 1'b1; cfg_sel = sel; cfg_code = code; cfg_prev_val = pv;
        @(posedge clk);
        m_code[sel] = code;
        m_pv[sel] = pv;
        @(negedge clk);
        cfg_we = 1'b0;
        check(victim_out, 1'b0, "victim_out in reset");
        check(fault_active, 1'b0, "fault_active in reset");
    endtask

    task automatic enter_reset();
        rst_n = 1'b0;
        victim_in = 1'b1; en = 1'b1; aggr = '1;
        @(negedge clk);
        cur_req = "R1";
        check(victim_out, 1'b0, "victim_out in reset");
        check(fault_active, 1'b0, "fault_active in reset");
        m_prev = '0;
        m_ok = 0;
    endtask

    task automatic leave_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 / R6: reset state, all terms loaded as disabled during reset
        enter_reset();
        for (int k = 0; k < NT; k++) wr_rst(k[SW-1:0], '0, '0);
        leave_reset();
        cur_req = "R6 disabled terms";
        for (int i = 0; i < 16; i++) cyc(i[0], 8'(i * 17), 1'b1);

        // R3 R4 R5 R2: mixed static and rising-edge terms, full sweeps
        cur_req = "R9 setup";
        cyc_w(1'b1, 2'd0, mk(8'h0F, 8'h0D, 8'h00), 8'h00, 1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd1, mk(8'hC0, 8'h80, 8'h00), 8'h00, 1'b1, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd3, mk(8'h20, 8'h20, 8'h20), 8'h00, 1'b0, 8'h00, 1'b1);
        cur_req = "R3 R5 sweep";
        for (int i = 0; i < 256; i++) cyc(i[0] ^ i[3], 8'(i), 1'b1);
        cur_req = "R4 R2 scrambled sweep";
        for (int i = 0; i < 256; i++) cyc(i[1], 8'((i * 37 + 11) & 255), 1'b1);

        // R7: enable low blocks every term
        cur_req = "R7 en low";
        for (int i = 0; i < 32; i++) cyc(i[2], 8'((i * 29 + 3) & 255), 1'b0);

        // R9: write in a cycle that matches only the new setting
        cur_req = "R9 write collides with eval";
        cyc(1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd2, mk(8'h02, 8'h02, 8'h00), 8'h00, 1'b0, 8'h02, 1'b1);
        check(fault_active, 1'b0, "old setting governs write cycle R9");
        cyc(1'b0, 8'h02, 1'b1);
        check(fault_active, 1'b1, "new setting next cycle R9");
        cyc(1'b1, 8'h0D, 1'b1);
        check(victim_out, 1'b0, "term0 kept after term2 write R9");

        // R5: event on bit2 with new value differing from bit4 (two products)
        cur_req = "R5 transition pair";
        cyc_w(1'b1, 2'd0, '0, '0, 1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd1, '0, '0, 1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd2, mk(8'h14, 8'h04, 8'h04), 8'h00, 1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd3, mk(8'h14, 8'h10, 8'h04), 8'h04, 1'b0, 8'h00, 1'b1);
        for (int i = 0; i < 256; i++) cyc(i[0], 8'((i * 73 + 5) & 255), 1'b1);
        cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h04, 1'b1);
        check(fault_active, 1'b1, "rising bit2 with bit4=0 R5");

        // R10: aggressor bit 0 tied to the victim
        cur_req = "R10 stuck-at-0";
        cyc_w(1'b1, 2'd2, '0, '0, 1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd3, '0, '0, 1'b0, 8'h00, 1'b1);
        cyc_w(1'b1, 2'd0, mk(8'h01, 8'h01, 8'h00), 8'h00, 1'b0, 8'h00, 1'b1);
        for (int i = 0; i < 16; i++) begin
            cyc(i[0], 8'((i * 16) | i[0]), 1'b1);
            check(victim_out, 1'b0, "stuck-at-0 output");
        end
        cur_req = "R10 stuck-at-1";
        cyc_w(1'b1, 2'd0, mk(8'h01, 8'h00, 8'h00), 8'h00, 1'b1, 8'h01, 1'b1);
        for (int i = 0; i < 16; i++) begin
            cyc(i[1], 8'((i * 16) | i[1]), 1'b1);
            check(victim_out, 1'b1, "stuck-at-1 output");
        end

        // R8: rising-edge term blocked in first cycle after reset
        enter_reset();
        wr_rst(2'd0, mk(8'h01, 8'h01, 8'h01), 8'h00);
        leave_reset();
        cur_req = "R8 dynamic warm-up";
        cyc(1'b0, 8'h01, 1'b1);
        check(fault_active, 1'b0, "dynamic term held off R8");
        cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b1, 8'h01, 1'b1);
        check(victim_out, 1'b0, "dynamic term after warm-up R8");

        // R8: static term may hit in first cycle after reset
        enter_reset();
        wr_rst(2'd0, mk(8'h80, 8'h80, 8'h00), 8'h00);
        leave_reset();
        cur_req = "R8 static first cycle";
        cyc(1'b0, 8'h80, 1'b1);
        check(fault_active, 1'b1, "static term in first cycle R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule